// File: doc/BRIEF.md
# Validation Coprocessor with Stall, Timed Interrupts and Timestamp

This block sits on a CPU's coprocessor handshake and gives test programs a small set of tools: sixteen shared 32-bit registers, a stall of a programmed length, a fast and a normal interrupt line that assert after a programmed delay, and a timestamp taken from a free-running cycle counter. It answers to two coprocessor numbers. Both numbers reach the registers with single-word transfers. Only the first number (4) accepts load/store transfers, which can be one beat or a long burst. Only the second number (5) offers the interrupt and timestamp operations.

Each request arrives as one cycle with a valid strobe, a handshake kind (first cycle, retry of a stalled operation, or data beat), a transfer class, the coprocessor number and the 32-bit instruction word. The response code is combinational within the same cycle. Read data also appears in that cycle. Register writes, counter loads and interrupt changes take effect at the clock edge that ends the request cycle.

Top module: `vcop_top`

## Requirements
- R1: After reset both interrupt lines are low, all sixteen registers read as zero, and the cycle counter starts at zero.
- R2: A request on any coprocessor number other than 4 or 5 gets response 3 (cannot) and changes nothing.
- R3: Class 0 (read) and class 1 (write) on number 4 or 5 get response 0 (done) and address the register given by instruction bits 19:16. Both numbers see the same registers. Read data appears in the same cycle.
- R4: Class 2 (load) and class 3 (store) are accepted only on number 4 and address the register in bits 15:12. On number 5 they get response 3 and write nothing. A kind other than 2 (data beat) answers done and restarts the beat count. A data beat with bit 22 clear answers done.
- R5: With bit 22 set, a burst of data beats answers 2 (increment) on its first four beats and done on the fifth, and every beat transfers data. A non-data request in the middle of a burst starts the count again.
- R6: Class 4 (execute) with operation bits 23:20 equal to 0 stalls on either number. On kind 0 (first) it reads count N from the register in bits 3:0 and answers done if N is 0, busy (1) otherwise. On kind 1 (retry) it answers done once the counter has reached its value at the first cycle plus N, and busy before that.
- R7: On number 4, execute with any nonzero operation answers cannot and has no effect on the interrupt lines.
- R8: On number 5, operation 1 (fast line) or 2 (normal line) with count N raises that line exactly N clock edges after the edge that ends the request (N = 0 means at that edge). Repeating the request while the countdown runs restarts it with the new count.
- R9: A raised line stays high until operation 3 (fast) or 4 (normal) on number 5 clears it at the end of that request. The clear also cancels a countdown that is still running.
- R10: On number 5, operation 5 writes the low 32 bits of the cycle counter, as it stood in the request cycle, into the register in bits 3:0. The counter advances by one on every clock edge.
- R11: On number 5, operations 6 to 15 answer cannot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cp_valid | input | 1 | A request is present this cycle |
| cp_kind | input | 2 | Handshake kind: 0 first, 1 retry, 2 data beat |
| cp_class | input | 3 | Transfer class: 0 read, 1 write, 2 load, 3 store, 4 execute |
| cp_num | input | 4 | Coprocessor number addressed |
| cp_instr | input | 32 | Instruction word holding register fields, operation and burst bit |
| cp_wdata | input | 32 | Data for write and load beats |
| cp_resp | output | 2 | Response: 0 done, 1 busy, 2 increment, 3 cannot |
| cp_rdata | output | 32 | Data for read and store beats, zero otherwise |
| fiq | output | 1 | Fast interrupt line |
| irq | output | 1 | Normal interrupt line |

## Verification
The assertions assume that at most one request is present per cycle. They also assume that a retry only follows a stall that has started, and that the cycle counter does not wrap within a run. The bench issues one request per task call with the valid strobe dropped in between, and begins every stall with a first-cycle request. Its runs are far too short for the 64-bit counter to wrap. Load and store bursts are always opened with a non-data request, so the beat count starts from a known value.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    K_FIRST = 2'd0,
    K_RETRY = 2'd1,
    K_DATA  = 2'd2
  } kind_e;

  typedef enum logic [2:0] {
    C_RD    = 3'd0,
    C_WR    = 3'd1,
    C_LOAD  = 3'd2,
    C_STORE = 3'd3,
    C_EXEC  = 3'd4
  } cls_e;

  typedef enum logic [1:0] {
    R_DONE = 2'd0,
    R_BUSY = 2'd1,
    R_INC  = 2'd2,
    R_CANT = 2'd3
  } resp_e;
endpackage

// File: rtl/vc_regfile.sv
module vc_regfile #(
  parameter int NREGS = 16,
  parameter int DW    = 32,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ra_idx,
  output logic [DW-1:0] ra_data,
  input  logic [IW-1:0] rb_idx,
  output logic [DW-1:0] rb_data
);
  logic [DW-1:0] rd_arr [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic          en;
    logic [DW-1:0] q;
    assign en = we && (widx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wdata;
    end
    assign rd_arr[g] = q;
  end

  assign ra_data = rd_arr[ra_idx];
  assign rb_data = rd_arr[rb_idx];

  // R3
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we && (ra_idx == widx) |=> $past(we) && (rd_arr[$past(widx)] == $past(wdata)));
endmodule

// File: rtl/vc_delay_irq.sv
module vc_delay_irq #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [CW-1:0] load_val,
  input  logic          clr,
  output logic          line
);
  logic          armed_q, armed_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          line_q, line_d;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    line_d  = line_q;
    if (clr) begin
      armed_d = 1'b0;
      line_d  = 1'b0;
    end else if (arm) begin
      if (load_val == '0) begin
        line_d  = 1'b1;
        armed_d = 1'b0;
      end else begin
        armed_d = 1'b1;
        cnt_d   = load_val;
      end
    end else if (armed_q) begin
      if (cnt_q == CW'(1)) begin
        line_d  = 1'b1;
        armed_d = 1'b0;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      line_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      line_q  <= line_d;
    end
  end

  assign line = line_q;

  // R9
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_q && !clr |=> line_q);
  // R9
  line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !line_q && !armed_q);
  // R8
  zero_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm && !clr && (load_val == '0) |=> line_q);
  // R8
  count_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && (cnt_q == CW'(1)) && !clr && !arm |=> line_q);
endmodule

// File: rtl/vc_ctrl.sv
module vc_ctrl
  import vc_pkg::*;
#(
  parameter int DW         = 32,
  parameter int CNT_W      = 64,
  parameter int LONG_BEATS = 5,
  parameter int CP_A       = 4,
  parameter int CP_B       = 5,
  parameter int IW         = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [1:0]       kind,
  input  logic [2:0]       cls,
  input  logic [3:0]       cpnum,
  input  logic [31:0]      instr,
  input  logic [DW-1:0]    wr_data,
  input  logic [CNT_W-1:0] now,
  input  logic [DW-1:0]    cnt_val,
  output logic [1:0]       resp,
  output logic [IW-1:0]    ra_idx,
  output logic [IW-1:0]    rb_idx,
  output logic             rd_en,
  output logic             we,
  output logic [IW-1:0]    widx,
  output logic [DW-1:0]    wdata,
  output logic             fiq_arm,
  output logic             fiq_clr,
  output logic             irq_arm,
  output logic             irq_clr
);
  localparam int BW = (LONG_BEATS > 1) ? $clog2(LONG_BEATS) : 1;
  localparam logic [BW-1:0] LAST = BW'(LONG_BEATS - 1);
  localparam logic [3:0] CPA = 4'(CP_A);
  localparam logic [3:0] CPB = 4'(CP_B);

  logic [3:0] op, crn, crd, crm;
  logic       burst, is_a, is_b, first;
  assign op    = instr[23:20];
  assign crn   = instr[19:16];
  assign crd   = instr[15:12];
  assign crm   = instr[3:0];
  assign burst = instr[22];
  assign is_a  = (cpnum == CPA);
  assign is_b  = (cpnum == CPB);
  assign first = (kind == K_FIRST);

  logic unused_bits;
  assign unused_bits = ^{instr[31:24], instr[11:4]};

  logic [BW-1:0]    beat_q, beat_d;
  logic [CNT_W-1:0] finish_q, finish_d;
  logic [CNT_W-1:0] wide_cnt;
  resp_e            resp_d;

  assign wide_cnt = {{(CNT_W-DW){1'b0}}, cnt_val};
  assign rb_idx   = IW'(crm);

  always_comb begin
    resp_d   = R_CANT;
    ra_idx   = IW'(crn);
    rd_en    = 1'b0;
    we       = 1'b0;
    widx     = IW'(crn);
    wdata    = wr_data;
    fiq_arm  = 1'b0;
    fiq_clr  = 1'b0;
    irq_arm  = 1'b0;
    irq_clr  = 1'b0;
    beat_d   = beat_q;
    finish_d = finish_q;
    if (valid) begin
      case (cls)
        C_RD: if (is_a || is_b) begin
          resp_d = R_DONE;
          rd_en  = 1'b1;
        end
        C_WR: if (is_a || is_b) begin
          resp_d = R_DONE;
          we     = 1'b1;
        end
        C_LOAD, C_STORE: if (is_a) begin
          if (kind != K_DATA) begin
            resp_d = R_DONE;
            beat_d = '0;
          end else begin
            ra_idx = IW'(crd);
            widx   = IW'(crd);
            we     = (cls == C_LOAD);
            rd_en  = (cls == C_STORE);
            if (burst && (beat_q != LAST)) begin
              resp_d = R_INC;
              beat_d = beat_q + 1'b1;
            end else begin
              resp_d = R_DONE;
              beat_d = '0;
            end
          end
        end
        C_EXEC: if ((is_a && op == 4'd0) || (is_b && op <= 4'd5)) begin
          case (op)
            4'd0: begin
              if (first) begin
                finish_d = now + wide_cnt;
                resp_d   = (cnt_val == '0) ? R_DONE : R_BUSY;
              end else if (kind == K_RETRY) begin
                resp_d = (now >= finish_q) ? R_DONE : R_BUSY;
              end
            end
            4'd1: begin resp_d = R_DONE; fiq_arm = first; end
            4'd2: begin resp_d = R_DONE; irq_arm = first; end
            4'd3: begin resp_d = R_DONE; fiq_clr = first; end
            4'd4: begin resp_d = R_DONE; irq_clr = first; end
            4'd5: begin
              resp_d = R_DONE;
              we     = first;
              widx   = IW'(crm);
              wdata  = now[DW-1:0];
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q   <= '0;
      finish_q <= '0;
    end else begin
      beat_q   <= beat_d;
      finish_q <= finish_d;
    end
  end

  assign resp = resp_d;

  // R5
  beat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_q <= LAST);
  // R5
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && (resp == R_INC) |=> beat_q == $past(beat_q) + 1'b1);
  // R11
  high_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && (cls == C_EXEC) && is_b && (op > 4'd5) |-> resp == R_CANT);
  // R6
  wait_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && (cls == C_EXEC) && (op == 4'd0) && (kind == K_RETRY) && (resp == R_DONE)
      |-> now >= finish_q);
  // R2
  foreign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !is_a && !is_b |-> (resp == R_CANT) && !we && !fiq_arm && !irq_arm);
endmodule

// File: rtl/vcop_top.sv
module vcop_top
  import vc_pkg::*;
#(
  parameter int NREGS      = 16,
  parameter int DW         = 32,
  parameter int CNT_W      = 64,
  parameter int LONG_BEATS = 5,
  parameter int CP_A       = 4,
  parameter int CP_B       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cp_valid,
  input  logic [1:0]    cp_kind,
  input  logic [2:0]    cp_class,
  input  logic [3:0]    cp_num,
  input  logic [31:0]   cp_instr,
  input  logic [DW-1:0] cp_wdata,
  output logic [1:0]    cp_resp,
  output logic [DW-1:0] cp_rdata,
  output logic          fiq,
  output logic          irq
);
  localparam int IW = $clog2(NREGS);

  logic [CNT_W-1:0] cyc_q, cyc_d;
  assign cyc_d = cyc_q + CNT_W'(1);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= '0;
    else        cyc_q <= cyc_d;
  end

  logic [IW-1:0] ra_idx, rb_idx, widx;
  logic [DW-1:0] ra_data, rb_data, wdata;
  logic          rd_en, we;
  logic [1:0]    arm_v, clr_v, line_v;

  vc_ctrl #(
    .DW(DW), .CNT_W(CNT_W), .LONG_BEATS(LONG_BEATS),
    .CP_A(CP_A), .CP_B(CP_B), .IW(IW)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .valid(cp_valid), .kind(cp_kind), .cls(cp_class), .cpnum(cp_num),
    .instr(cp_instr), .wr_data(cp_wdata), .now(cyc_q), .cnt_val(rb_data),
    .resp(cp_resp), .ra_idx(ra_idx), .rb_idx(rb_idx), .rd_en(rd_en),
    .we(we), .widx(widx), .wdata(wdata),
    .fiq_arm(arm_v[0]), .fiq_clr(clr_v[0]),
    .irq_arm(arm_v[1]), .irq_clr(clr_v[1])
  );

  vc_regfile #(.NREGS(NREGS), .DW(DW)) i_regs (
    .clk(clk), .rst_n(rst_n), .we(we), .widx(widx), .wdata(wdata),
    .ra_idx(ra_idx), .ra_data(ra_data), .rb_idx(rb_idx), .rb_data(rb_data)
  );

  for (genvar g = 0; g < 2; g++) begin : g_line
    vc_delay_irq #(.CW(DW)) i_dly (
      .clk(clk), .rst_n(rst_n), .arm(arm_v[g]), .load_val(rb_data),
      .clr(clr_v[g]), .line(line_v[g])
    );
  end

  assign fiq      = line_v[0];
  assign irq      = line_v[1];
  assign cp_rdata = rd_en ? ra_data : '0;

  // R10
  counter_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cyc_q == $past(cyc_q) + CNT_W'(1));
endmodule

// File: tb/test_vcop_top.sv
module test_vcop_top;
  localparam logic [1:0] KF = 2'd0, KR = 2'd1, KD = 2'd2;
  localparam logic [2:0] CRD = 3'd0, CWR = 3'd1, CLD = 3'd2, CST = 3'd3, CEX = 3'd4;
  localparam logic [1:0] DONE = 2'd0, BUSY = 2'd1, INC = 2'd2, CANT = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cp_valid;
  logic [1:0]  cp_kind;
  logic [2:0]  cp_class;
  logic [3:0]  cp_num;
  logic [31:0] cp_instr, cp_wdata, cp_rdata;
  logic [1:0]  cp_resp;
  logic        fiq, irq;

  always #2 clk = ~clk;

  vcop_top i_vcop_top (
    .clk(clk), .rst_n(rst_n), .cp_valid(cp_valid), .cp_kind(cp_kind),
    .cp_class(cp_class), .cp_num(cp_num), .cp_instr(cp_instr),
    .cp_wdata(cp_wdata), .cp_resp(cp_resp), .cp_rdata(cp_rdata),
    .fiq(fiq), .irq(irq)
  );

  int          n_chk = 0, n_err = 0;
  bit          fin = 1'b0;
  longint      tb_cyc;
  logic [1:0]  r_resp;
  logic [31:0] r_data;
  longint      r_cyc;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) tb_cyc <= 0;
    else        tb_cyc <= tb_cyc + 1;

  function automatic logic [31:0] mk(int op, int crn, int crd, int lng, int crm);
    return (32'(op) << 20) | (32'(crn) << 16) | (32'(crd) << 12) | (32'(lng) << 22) | 32'(crm);
  endfunction

  function automatic logic [31:0] pat(int i);
    return 32'hA5000000 ^ (32'(i) * 32'h01010101) ^ 32'(i << 4);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic req(input logic [1:0] k, input logic [2:0] c, input int cp,
                     input logic [31:0] ins, input logic [31:0] wd);
    cp_valid = 1'b1; cp_kind = k; cp_class = c; cp_num = 4'(cp);
    cp_instr = ins; cp_wdata = wd;
    #1;
    r_resp = cp_resp; r_data = cp_rdata; r_cyc = tb_cyc;
    @(posedge clk); #1;
    cp_valid = 1'b0; cp_kind = 2'd3; cp_class = 3'd7;
    @(negedge clk);
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rd(input int cp, input int r);
    req(KF, CRD, cp, mk(0, r, 0, 0, 0), 32'h0);
  endtask

  task automatic wr(input int cp, input int r, input logic [31:0] v);
    req(KF, CWR, cp, mk(0, r, 0, 0, 0), v);
  endtask

  function automatic logic line_of(int w);
    return (w == 0) ? fiq : irq;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cp_valid = 1'b0; cp_kind = 2'd3; cp_class = 3'd7;
    cp_num = 4'd0; cp_instr = '0; cp_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(fiq == 1'b0 && irq == 1'b0, "R1 lines", {fiq, irq}, 0);
    for (int i = 0; i < 16; i++) begin
      rd(4, i);
      chk(r_data == 32'h0, "R1 reg zero", r_data, 0);
    end

    // R2 foreign numbers
    for (int cp = 0; cp < 16; cp++) begin
      rd(cp, 0);
      chk(r_resp == ((cp == 4 || cp == 5) ? DONE : CANT), "R2 number", r_resp,
          (cp == 4 || cp == 5) ? DONE : CANT);
    end
    req(KF, CWR, 7, mk(0, 1, 0, 0, 0), 32'hDEAD);
    rd(4, 1);
    chk(r_data == 32'h0, "R2 no write", r_data, 0);

    // R3 write on one number, read on the other
    for (int i = 0; i < 16; i++) begin
      wr((i % 2) ? 5 : 4, i, pat(i));
      chk(r_resp == DONE, "R3 write resp", r_resp, DONE);
    end
    for (int i = 0; i < 16; i++) begin
      rd((i % 2) ? 4 : 5, i);
      chk(r_resp == DONE && r_data == pat(i), "R3 read", r_data, pat(i));
    end

    // R4 load/store single beats
    req(KD, CLD, 5, mk(0, 0, 3, 0, 0), 32'h12345678);
    chk(r_resp == CANT, "R4 load on 5", r_resp, CANT);
    rd(4, 3);
    chk(r_data == pat(3), "R4 load on 5 no write", r_data, pat(3));
    req(KF, CST, 5, mk(0, 0, 3, 0, 0), 0);
    chk(r_resp == CANT, "R4 store on 5", r_resp, CANT);
    req(KF, CST, 4, mk(0, 0, 0, 0, 0), 0);
    chk(r_resp == DONE, "R4 store first", r_resp, DONE);
    for (int i = 0; i < 16; i++) begin
      req(KD, CST, 4, mk(0, 0, i, 0, 0), 0);
      chk(r_resp == DONE && r_data == pat(i), "R4 store beat", r_data, pat(i));
    end
    req(KF, CLD, 4, mk(0, 0, 2, 0, 0), 0);
    req(KD, CLD, 4, mk(0, 0, 2, 0, 0), 32'h0BADF00D);
    chk(r_resp == DONE, "R4 load beat resp", r_resp, DONE);
    rd(5, 2);
    chk(r_data == 32'h0BADF00D, "R4 load beat data", r_data, 32'h0BADF00D);

    // R5 long bursts
    req(KF, CLD, 4, mk(0, 0, 7, 1, 0), 0);
    for (int b = 0; b < 5; b++) begin
      req(KD, CLD, 4, mk(0, 0, 7, 1, 0), 32'h700 + 32'(b));
      chk(r_resp == ((b < 4) ? INC : DONE), "R5 load burst", r_resp, (b < 4) ? INC : DONE);
    end
    rd(4, 7);
    chk(r_data == 32'h704, "R5 last beat kept", r_data, 32'h704);
    req(KF, CST, 4, mk(0, 0, 7, 1, 0), 0);
    for (int b = 0; b < 5; b++) begin
      req(KD, CST, 4, mk(0, 0, 7, 1, 0), 0);
      chk(r_resp == ((b < 4) ? INC : DONE) && r_data == 32'h704, "R5 store burst",
          {r_resp, r_data}, {((b < 4) ? INC : DONE), 32'h704});
    end
    req(KF, CST, 4, mk(0, 0, 7, 1, 0), 0);
    req(KD, CST, 4, mk(0, 0, 7, 1, 0), 0);
    req(KD, CST, 4, mk(0, 0, 7, 1, 0), 0);
    req(KF, CST, 4, mk(0, 0, 7, 1, 0), 0);
    chk(r_resp == DONE, "R5 restart resp", r_resp, DONE);
    for (int b = 0; b < 5; b++) begin
      req(KD, CST, 4, mk(0, 0, 7, 1, 0), 0);
      chk(r_resp == ((b < 4) ? INC : DONE), "R5 restarted burst", r_resp, (b < 4) ? INC : DONE);
    end

    // R6 stall sweep, back-to-back retries
    for (int n = 0; n < 7; n++) begin
      longint t0;
      wr(4, 9, 32'(n));
      req(KF, CEX, (n % 2) ? 5 : 4, mk(0, 0, 0, 0, 9), 0);
      t0 = r_cyc;
      chk(r_resp == ((n == 0) ? DONE : BUSY), "R6 first", r_resp, (n == 0) ? DONE : BUSY);
      for (int k = 1; k <= n; k++) begin
        req(KR, CEX, (n % 2) ? 5 : 4, mk(0, 0, 0, 0, 9), 0);
        chk(r_resp == ((r_cyc >= t0 + n) ? DONE : BUSY), "R6 retry", r_resp,
            (r_cyc >= t0 + n) ? DONE : BUSY);
      end
    end
    begin
      longint t0;
      wr(4, 9, 32'd6);
      req(KF, CEX, 4, mk(0, 0, 0, 0, 9), 0);
      t0 = r_cyc;
      repeat (3) idle();
      for (int k = 0; k < 4; k++) begin
        req(KR, CEX, 4, mk(0, 0, 0, 0, 9), 0);
        chk(r_resp == ((r_cyc >= t0 + 6) ? DONE : BUSY), "R6 retry after gap", r_resp,
            (r_cyc >= t0 + 6) ? DONE : BUSY);
      end
    end

    // R7 number 4 rejects other operations
    wr(4, 10, 32'd0);
    for (int op = 1; op < 16; op++) begin
      req(KF, CEX, 4, mk(op, 0, 0, 0, 10), 0);
      chk(r_resp == CANT, "R7 op on 4", r_resp, CANT);
    end
    idle();
    chk(fiq == 1'b0 && irq == 1'b0, "R7 no line change", {fiq, irq}, 0);

    // R8 and R9 delay sweep on both lines
    for (int w = 0; w < 2; w++) begin
      for (int n = 0; n < 6; n++) begin
        wr(5, 10, 32'(n));
        req(KF, CEX, 5, mk(1 + w, 0, 0, 0, 10), 0);
        chk(r_resp == DONE, "R8 arm resp", r_resp, DONE);
        for (int k = 0; k <= n + 1; k++) begin
          chk(line_of(w) == (k >= n), "R8 delay", line_of(w), (k >= n));
          chk(line_of(1 - w) == 1'b0, "R8 other line", line_of(1 - w), 0);
          idle();
        end
        req(KF, CEX, 5, mk(3 + w, 0, 0, 0, 0), 0);
        chk(line_of(w) == 1'b0, "R9 clear", line_of(w), 0);
      end
    end
    wr(5, 10, 32'd0);
    req(KF, CEX, 5, mk(1, 0, 0, 0, 10), 0);
    repeat (10) idle();
    chk(fiq == 1'b1, "R9 hold", fiq, 1);
    req(KF, CEX, 5, mk(4, 0, 0, 0, 0), 0);
    chk(fiq == 1'b1, "R9 other clear leaves line", fiq, 1);
    req(KF, CEX, 5, mk(3, 0, 0, 0, 0), 0);
    chk(fiq == 1'b0, "R9 clear after hold", fiq, 0);
    wr(5, 10, 32'd5);
    req(KF, CEX, 5, mk(1, 0, 0, 0, 10), 0);
    idle();
    wr(5, 11, 32'd3);
    req(KF, CEX, 5, mk(1, 0, 0, 0, 11), 0);
    idle(); idle();
    chk(fiq == 1'b0, "R8 reload not yet", fiq, 0);
    idle();
    chk(fiq == 1'b1, "R8 reload fires", fiq, 1);
    req(KF, CEX, 5, mk(3, 0, 0, 0, 0), 0);
    wr(5, 10, 32'd4);
    req(KF, CEX, 5, mk(2, 0, 0, 0, 10), 0);
    req(KF, CEX, 5, mk(4, 0, 0, 0, 0), 0);
    repeat (6) idle();
    chk(irq == 1'b0, "R9 clear cancels countdown", irq, 0);

    // R10 timestamp
    for (int j = 0; j < 3; j++) begin
      longint ts;
      req(KF, CEX, 5, mk(5, 0, 0, 0, 12), 0);
      ts = r_cyc;
      chk(r_resp == DONE, "R10 resp", r_resp, DONE);
      rd(4, 12);
      chk(r_data == 32'(ts), "R10 stamp", r_data, 32'(ts));
      repeat (j * 7) idle();
    end

    // R11 high operations on number 5
    for (int op = 6; op < 16; op++) begin
      req(KF, CEX, 5, mk(op, 0, 0, 0, 10), 0);
      chk(r_resp == CANT, "R11 op on 5", r_resp, CANT);
    end

    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule